// File: doc/BRIEF.md
# SMBus Register-Access Slave

This block is a slave-only serial port in the SMBus/I2C style that lets a bus host read and write a bank of 8-bit registers kept outside the block. The block oversamples the SCL and SDA lines with the system clock. It detects START, repeated START and STOP, and it answers to the 7-bit address `010110x`, where `x` is the level of an address-select pin. It pulls SDA low through an open-drain enable and never drives the line high.

Four transaction shapes are accepted. Write Byte carries a register number and one data byte. Read Byte carries a register number, then a repeated START and one byte returned to the host. Send Byte carries a register number only. Receive Byte returns one byte. The register number is kept in a pointer that survives between transactions, so a Receive Byte reads whatever the last Send Byte or Read Byte selected.

A write reaches the register file only when the Write Byte sequence has been completed and closed by STOP. Any other ending leaves the register file untouched.

Top module: `smb_reg_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth clock) an address byte whose upper seven bits equal `0101 10` followed by `addr_sel`. It leaves any other address unacknowledged. Bit 0 of the address byte selects read (1) or write (0).
- R2: After an address that does not match, the block acknowledges no further byte and writes nothing until the next START.
- R3: A Write Byte transaction (address with write bit, register number, one data byte, each shifted MSB first, each acknowledged, then STOP) produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the register number and `reg_wdata` equal to the data byte.
- R4: A write closed by a repeated START, or by a STOP before the data byte's acknowledge is complete, produces no `reg_we` pulse.
- R5: A second data byte in a write is not acknowledged, and the transaction then commits nothing.
- R6: The register number of a Send Byte loads the pointer. A following Receive Byte returns the register at that pointer.
- R7: Read Byte returns the register selected by its register number, and the pointer keeps that value for later Receive Byte transactions.
- R8: After reset the pointer is 0x00.
- R9: When the block returns a byte, it releases SDA after the eighth bit so the host can NACK it. SDA is released during the host's acknowledge bit and after STOP.
- R10: A STOP seen in the middle of a byte abandons the transaction, and the next transaction runs normally.
- R11: During and right after reset, `sda_oe` and `reg_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Sets the least significant address bit |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Data for a committed write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
The bench builds the block with three synchronizer stages and the agreement filter on. This gives the longest delay from a bus edge to an internal event, so the test shows that acknowledge and data bits still settle well inside the low phase of SCL. A bus quarter-period of twelve clocks keeps every data change clear of SCL edges, so the START and STOP detectors see only the intended conditions. The test toggles the address-select pin between the two matching addresses. It also covers early, late and extra-byte endings of a write.

// File: rtl/smb_pkg.sv
package smb_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_CMD,
      ST_CMD_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_WAIT_STOP,
      ST_RDATA,
      ST_RD_ACK,
      ST_IGNORE
   } smb_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES    = 2,
   parameter bit FILTER_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("smb_line_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= din;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din};
         end
      end

      if (FILTER_EN) begin : g_filter
         logic last_q, lvl_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q <= 1'b1;
               lvl_q  <= 1'b1;
            end else begin
               last_q <= chain_q[STAGES-1];
               if (chain_q[STAGES-1] == last_q) lvl_q <= last_q;
            end
         end
         assign dout = lvl_q;
      end else begin : g_plain
         assign dout = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_lvl;
         sda_p <= sda_lvl;
      end
   end

   assign scl_rise  =  scl_lvl & ~scl_p;
   assign scl_fall  = ~scl_lvl &  scl_p;
   assign start_det =  scl_lvl &  scl_p & sda_p & ~sda_lvl;
   assign stop_det  =  scl_lvl &  scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
   import smb_pkg::*;
#(
   parameter logic [5:0]        ADDR_UPPER = 6'b010110,
   parameter logic [BYTE_W-1:0] PTR_RST    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_sel,
   input  logic              sda_bit,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rdata,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] ptr,
   output logic [BYTE_W-1:0] wdata,
   output logic              we
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   smb_state_e        state_q;
   logic [CNT_W-1:0]  bit_q;
   logic [BYTE_W-1:0] shift_q, ptr_q, wbuf_q;
   logic              rnw_q, oe_q, we_q;
   logic [6:0]        my_addr;

   assign my_addr = {ADDR_UPPER, addr_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         shift_q <= '0;
         ptr_q   <= PTR_RST;
         wbuf_q  <= '0;
         rnw_q   <= 1'b0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (stop_det) begin
            if (state_q == ST_WAIT_STOP) we_q <= 1'b1;
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
            bit_q   <= '0;
         end else if (start_det) begin
            state_q <= ST_ADDR;
            oe_q    <= 1'b0;
            bit_q   <= '0;
         end else begin
            case (state_q)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise && bit_q != FULL) begin
                     shift_q <= {shift_q[BYTE_W-2:0], sda_bit};
                     bit_q   <= bit_q + 1'b1;
                  end else if (scl_fall && bit_q == FULL) begin
                     bit_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (shift_q[BYTE_W-1:1] == my_addr) begin
                           rnw_q   <= shift_q[0];
                           oe_q    <= 1'b1;
                           state_q <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_IGNORE;
                        end
                     end else if (state_q == ST_CMD) begin
                        ptr_q   <= shift_q;
                        oe_q    <= 1'b1;
                        state_q <= ST_CMD_ACK;
                     end else begin
                        wbuf_q  <= shift_q;
                        oe_q    <= 1'b1;
                        state_q <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     if (rnw_q) begin
                        shift_q <= rdata;
                        oe_q    <= ~rdata[BYTE_W-1];
                        state_q <= ST_RDATA;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK: begin
                  if (scl_fall) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_WDATA;
                  end
               end
               ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_WAIT_STOP;
                  end
               end
               ST_WAIT_STOP: begin
                  if (scl_fall) state_q <= ST_IGNORE;
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bit_q <= bit_q + 1'b1;
                  end else if (scl_fall && bit_q == FULL) begin
                     oe_q    <= 1'b0;
                     bit_q   <= '0;
                     state_q <= ST_RD_ACK;
                  end else if (scl_fall && bit_q != '0) begin
                     shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                     oe_q    <= ~shift_q[BYTE_W-2];
                  end
               end
               ST_RD_ACK: begin
                  if (scl_fall) state_q <= ST_IGNORE;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = oe_q;
   assign ptr    = ptr_q;
   assign wdata  = wbuf_q;
   assign we     = we_q;

   // R3: the write strobe lasts one cycle
   a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |=> !we_q);
   // R4: a strobe only follows a finished data acknowledge
   a_r4_we_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> $past(state_q == ST_WAIT_STOP));
   // R10: STOP always returns the controller to idle
   a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state_q == ST_IDLE && !oe_q));
   // R9: SDA is only grabbed while SCL is low
   a_r9_grab_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(scl_fall));
   // R9: SDA is released at an SCL fall or a bus condition
   a_r9_release_timing: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_q) |-> $past(scl_fall || start_det || stop_det));
   // R2: a silent slave never drives the bus
   a_r2_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IGNORE) |-> !oe_q);
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
   import smb_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter bit                FILTER_EN   = 1'b1,
   parameter logic [5:0]        ADDR_UPPER  = 6'b010110,
   parameter logic [BYTE_W-1:0] PTR_RST     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_sel,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);
   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw, lvl;
   logic scl_rise, scl_fall, start_det, stop_det;

   assign raw = {scl_i, sda_i};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         smb_line_sync #(.STAGES(SYNC_STAGES), .FILTER_EN(FILTER_EN)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (lvl[g])
         );
      end
   endgenerate

   smb_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (lvl[1]),
      .sda_lvl  (lvl[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   smb_xfer_fsm #(.ADDR_UPPER(ADDR_UPPER), .PTR_RST(PTR_RST)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_sel (addr_sel),
      .sda_bit  (lvl[0]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .rdata    (reg_rdata),
      .sda_oe   (sda_oe),
      .ptr      (reg_addr),
      .wdata    (reg_wdata),
      .we       (reg_we)
   );

   // R11: nothing is driven and nothing written while reset is held
   always_comb begin
      if (!rst_n) a_r11_reset_quiet: assert (!sda_oe && !reg_we);
   end
endmodule

// File: tb/smb_reg_slave_tb.sv
module smb_reg_slave_tb;
   localparam int Q = 12;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n, scl, host_low, addr_sel;
   logic sda_line, sda_oe, reg_we;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic [7:0] bank [256];
   logic [7:0] exp_mem [256];
   logic [15:0] wq [$];
   logic [15:0] popped;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   assign sda_line = !(host_low || sda_oe);

   smb_reg_slave #(.SYNC_STAGES(3), .FILTER_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
      .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata)
   );

   assign reg_rdata = bank[reg_addr];
   always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares every write strobe with the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         if (wq.size() == 0) chk(1'b0, "R4 unexpected write", {reg_addr, reg_wdata}, 16'h0000);
         else begin
            popped = wq.pop_front();
            chk({reg_addr, reg_wdata} == popped, "R3 committed write", {reg_addr, reg_wdata}, popped);
         end
      end
   end

   task automatic wq_t(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      host_low = 0; scl = 1; wq_t(); host_low = 1; wq_t(); scl = 0; wq_t();
   endtask
   task automatic bus_rstart();
      host_low = 0; wq_t(); scl = 1; wq_t(); host_low = 1; wq_t(); scl = 0; wq_t();
   endtask
   task automatic bus_stop();
      host_low = 1; wq_t(); scl = 1; wq_t(); host_low = 0; wq_t(); wq_t();
   endtask
   task automatic put_bit(input logic b);
      host_low = !b; wq_t(); scl = 1; wq_t(); wq_t(); scl = 0; wq_t();
   endtask
   task automatic get_bit(output logic b);
      host_low = 0; wq_t(); scl = 1; wq_t(); b = sda_line; wq_t(); scl = 0; wq_t();
   endtask
   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(a);
      ack = !a;
   endtask
   task automatic recv_byte(output logic [7:0] v, input logic nack);
      logic b;
      for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
      put_bit(nack);
   endtask

   task automatic do_write(input logic [6:0] a7, input logic [7:0] r, input logic [7:0] d);
      logic ack;
      bus_start();
      send_byte({a7, 1'b0}, ack); chk(ack, "R1 address ack", {15'h0, ack}, 16'h1);
      send_byte(r, ack);          chk(ack, "R3 register ack", {15'h0, ack}, 16'h1);
      send_byte(d, ack);          chk(ack, "R3 data ack", {15'h0, ack}, 16'h1);
      wq.push_back({r, d});
      bus_stop(); wq_t();
      exp_mem[r] = d;
   endtask
   task automatic do_read(input logic [6:0] a7, input logic [7:0] r, output logic [7:0] v);
      logic ack;
      bus_start();
      send_byte({a7, 1'b0}, ack);
      send_byte(r, ack);
      bus_rstart();
      send_byte({a7, 1'b1}, ack); chk(ack, "R7 read address ack", {15'h0, ack}, 16'h1);
      recv_byte(v, 1'b1);
      chk(!sda_oe, "R9 released after NACK", {15'h0, sda_oe}, 16'h0);
      bus_stop();
   endtask
   task automatic do_recv(input logic [6:0] a7, output logic [7:0] v);
      logic ack;
      bus_start();
      send_byte({a7, 1'b1}, ack); chk(ack, "R6 receive address ack", {15'h0, ack}, 16'h1);
      recv_byte(v, 1'b1);
      bus_stop();
   endtask
   task automatic do_send(input logic [6:0] a7, input logic [7:0] r);
      logic ack;
      bus_start();
      send_byte({a7, 1'b0}, ack);
      send_byte(r, ack); chk(ack, "R6 send byte ack", {15'h0, ack}, 16'h1);
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic ack;
      for (int i = 0; i < 256; i++) begin
         bank[i] = 8'(i * 7 + 3);
         exp_mem[i] = 8'(i * 7 + 3);
      end
      rst_n = 0; scl = 1; host_low = 0; addr_sel = 1;
      repeat (5) @(negedge clk);
      chk(!sda_oe && !reg_we, "R11 reset outputs", {14'h0, sda_oe, reg_we}, 16'h0);
      rst_n = 1;
      repeat (5) @(negedge clk);
      chk(!sda_oe && !reg_we, "R11 after reset", {14'h0, sda_oe, reg_we}, 16'h0);

      // R8: pointer starts at 0
      do_recv(7'h2D, v);
      chk(v == exp_mem[0], "R8 pointer reset", {8'h0, v}, {8'h0, exp_mem[0]});

      // R3 / R7: write then read back
      do_write(7'h2D, 8'h33, 8'hA5);
      do_read(7'h2D, 8'h33, v);
      chk(v == 8'hA5, "R7 read byte", {8'h0, v}, 16'h00A5);

      // R6: send byte then receive byte, twice (pointer persists)
      do_send(7'h2D, 8'h10);
      do_recv(7'h2D, v);
      chk(v == exp_mem[8'h10], "R6 receive at pointer", {8'h0, v}, {8'h0, exp_mem[8'h10]});
      do_recv(7'h2D, v);
      chk(v == exp_mem[8'h10], "R7 pointer persists", {8'h0, v}, {8'h0, exp_mem[8'h10]});

      // R1 / R2: wrong address while addr_sel=1
      bus_start();
      send_byte({7'h2C, 1'b0}, ack); chk(!ack, "R1 foreign address no ack", {15'h0, ack}, 16'h0);
      send_byte(8'h20, ack);         chk(!ack, "R2 ignored byte", {15'h0, ack}, 16'h0);
      send_byte(8'h77, ack);         chk(!ack, "R2 ignored data", {15'h0, ack}, 16'h0);
      bus_stop(); wq_t();

      // R1: addr_sel=0 moves the address
      addr_sel = 0;
      do_write(7'h2C, 8'h40, 8'h3C);
      do_read(7'h2C, 8'h40, v);
      chk(v == 8'h3C, "R1 alternate address", {8'h0, v}, 16'h003C);

      // R4: stop inside the data byte
      bus_start();
      send_byte({7'h2C, 1'b0}, ack);
      send_byte(8'h40, ack);
      for (int i = 0; i < 4; i++) put_bit(1'b0);
      bus_stop(); wq_t();
      // R4: repeated start after the data acknowledge
      bus_start();
      send_byte({7'h2C, 1'b0}, ack);
      send_byte(8'h40, ack);
      send_byte(8'h99, ack);
      bus_rstart();
      send_byte({7'h2C, 1'b1}, ack);
      recv_byte(v, 1'b1);
      bus_stop();
      chk(v == 8'h3C, "R4 truncated writes kept old value", {8'h0, v}, 16'h003C);

      // R5: two data bytes
      bus_start();
      send_byte({7'h2C, 1'b0}, ack);
      send_byte(8'h41, ack);
      send_byte(8'h12, ack);
      send_byte(8'h34, ack); chk(!ack, "R5 extra byte not acked", {15'h0, ack}, 16'h0);
      bus_stop(); wq_t();
      do_read(7'h2C, 8'h41, v);
      chk(v == exp_mem[8'h41], "R5 no commit", {8'h0, v}, {8'h0, exp_mem[8'h41]});

      // R10: stop in the middle of the address byte
      bus_start();
      for (int i = 0; i < 3; i++) put_bit(1'b0);
      bus_stop();
      chk(!sda_oe, "R10 abort releases bus", {15'h0, sda_oe}, 16'h0);
      do_write(7'h2C, 8'hF0, 8'h5E);
      do_read(7'h2C, 8'hF0, v);
      chk(v == 8'h5E, "R10 recovery write", {8'h0, v}, 16'h005E);

      repeat (20) @(negedge clk);
      chk(wq.size() == 0, "R3 all expected writes seen", 16'(wq.size()), 16'h0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule